// File: doc/BRIEF.md
# Codec power-up sequencer

This block runs on the host side of a multichannel audio codec and takes it from supply-on to normal operation. It holds the codec reset line low until supplies and clocks are good, then waits a reference-settling interval counted in millisecond ticks. After that it sends an ordered list of register writes over a simple valid/ready request port. The list puts the codec into power-down, loads a configuration table with power-down still set, mutes every DAC, and then clears power-down.

After power-down is cleared, the block counts rising edges of the frame clock (LRCK). It first waits out the initialization interval and then a short guard interval, after which it issues the unmute write. A brownout or a loss of supply-good in any state sends it back to the reset state, and the whole order starts again. The control-port serializer that turns the write requests into bus traffic sits outside this block.

Top module: `codec_pwrup_seq`

## Requirements
- R1: While `rst_ni` is low or `pwr_good_i` is low, `codec_rst_n_o` is low, `wr_valid_o` is low and `ready_o` is low.
- R2: Once supply-good rises with no brownout, `codec_rst_n_o` goes high. No write is requested until exactly `SETTLE_MS` cycles with `ms_tick_i` high have been seen.
- R3: The first write after settling targets `PDN_ADDR` (default 0x02) with data 0x01, meaning the power-down bit (bit 0) is set.
- R4: Next come `CFG_N` configuration writes in table order. Entry i has address `CFG_BASE`+i and data ((i*29) xor 0xA5) truncated to 8 bits.
- R5: After the table, the block writes `MUTE_VAL` (default 0xFF) to `MUTE_ADDR` (default 0x05), then writes 0x00 to `PDN_ADDR`. The mute write therefore comes before power-down is cleared.
- R6: After the power-down-clear write is accepted, no write is requested until `INIT_LRCK`+`UNMUTE_LRCK` rising edges of `lrck_i` have been counted. Then the unmute write (`MUTE_ADDR`, `UNMUTE_VAL` = 0x00) is requested.
- R7: `ready_o` rises in the cycle after the unmute write is accepted and stays high. `busy_o` is high from reset release until then.
- R8: A request holds `wr_valid_o`, `wr_addr_o` and `wr_data_o` steady until the cycle in which `wr_ready_i` is high, which completes exactly one write.
- R9: A high `brownout_i` or a low `pwr_good_i` in any state drives `codec_rst_n_o`, `ready_o` and `wr_valid_o` low one cycle later. The full order from R2 then repeats.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pwr_good_i | input | 1 | Supplies and clocks are stable |
| brownout_i | input | 1 | Supply dropped below operating range |
| lrck_i | input | 1 | Codec frame clock, asynchronous |
| ms_tick_i | input | 1 | One-cycle pulse each millisecond |
| codec_rst_n_o | output | 1 | Codec reset, active low |
| wr_addr_o | output | ADDR_W | Register address of the pending write |
| wr_data_o | output | DATA_W | Register data of the pending write |
| wr_valid_o | output | 1 | Write request pending |
| wr_ready_i | input | 1 | Write accepted this cycle |
| ready_o | output | 1 | Codec initialized and unmuted |
| busy_o | output | 1 | Bring-up in progress |

## Verification
A wrong state or index shows up as a wrong (address, data) pair, or a pair in the wrong place, in the write log, and it appears at the very next handshake. A wrong wait count shows up as a shifted number of ticks or LRCK edges before the next request, so it is visible at the end of that wait. A fault-path error shows up one cycle after the brownout or supply drop, as reset, ready or valid failing to go low.

// File: rtl/codec_pwrup_pkg.sv
package codec_pwrup_pkg;

  typedef enum logic [3:0] {
    ST_RESET,
    ST_SETTLE,
    ST_PDN_SET,
    ST_CFG,
    ST_MUTE,
    ST_PDN_CLR,
    ST_INIT_WAIT,
    ST_UNMUTE_WAIT,
    ST_UNMUTE,
    ST_READY
  } seq_state_e;

  // configuration table content, computed rather than listed
  function automatic logic [7:0] cfg_value(int unsigned idx);
    int unsigned v;
    v = (idx * 29) ^ 32'd165;
    return v[7:0];
  endfunction

endpackage

// File: rtl/codec_lrck_edge.sv
module codec_lrck_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lrck_i,
  output logic rise_o
);
  logic [1:0] sync_q;
  logic       prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[0], lrck_i};
      prev_q <= sync_q[1];
    end
  end

  assign rise_o = sync_q[1] & ~prev_q;

  // R6: an edge is reported for one cycle only
  p_rise_single_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> !rise_o);

endmodule

// File: rtl/codec_evt_timer.sv
module codec_evt_timer #(
  parameter int CNT_W = 9
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             evt_i,
  input  logic [CNT_W-1:0] limit_i,
  output logic             hit_o
);
  logic [CNT_W-1:0] cnt_q;

  assign hit_o = en_i && evt_i && (cnt_q == limit_i - CNT_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (!en_i || hit_o)    cnt_q <= '0;
    else if (evt_i)             cnt_q <= cnt_q + CNT_W'(1);
  end

  // R6: counter never passes the active limit
  p_cnt_in_range_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i |-> (cnt_q < limit_i));

endmodule

// File: rtl/codec_cfg_rom.sv
module codec_cfg_rom
  import codec_pwrup_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 8,
  parameter int CFG_N    = 4,
  parameter int CFG_BASE = 6,
  parameter int IDX_W    = 2
) (
  input  logic [IDX_W-1:0]  idx_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] data_o
);
  logic [ADDR_W-1:0] tbl_addr [CFG_N];
  logic [DATA_W-1:0] tbl_data [CFG_N];

  for (genvar g = 0; g < CFG_N; g++) begin : g_ent
    assign tbl_addr[g] = ADDR_W'(CFG_BASE + g);
    assign tbl_data[g] = DATA_W'(cfg_value(g));
  end

  assign addr_o = tbl_addr[idx_i];
  assign data_o = tbl_data[idx_i];

endmodule

// File: rtl/codec_pwrup_seq.sv
module codec_pwrup_seq
  import codec_pwrup_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int DATA_W      = 8,
  parameter int CFG_N       = 4,
  parameter int CFG_BASE    = 6,
  parameter int PDN_ADDR    = 2,
  parameter int MUTE_ADDR   = 5,
  parameter int MUTE_VAL    = 255,
  parameter int UNMUTE_VAL  = 0,
  parameter int SETTLE_MS   = 400,
  parameter int INIT_LRCK   = 2000,
  parameter int UNMUTE_LRCK = 90
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pwr_good_i,
  input  logic              brownout_i,
  input  logic              lrck_i,
  input  logic              ms_tick_i,
  output logic              codec_rst_n_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [DATA_W-1:0] wr_data_o,
  output logic              wr_valid_o,
  input  logic              wr_ready_i,
  output logic              ready_o,
  output logic              busy_o
);
  localparam int MAX_A    = (SETTLE_MS > INIT_LRCK) ? SETTLE_MS : INIT_LRCK;
  localparam int MAX_WAIT = (MAX_A > UNMUTE_LRCK) ? MAX_A : UNMUTE_LRCK;
  localparam int CNT_W    = $clog2(MAX_WAIT + 1);
  localparam int IDX_W    = (CFG_N > 1) ? $clog2(CFG_N) : 1;

  seq_state_e        state_q, state_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic              fault, lrck_rise, tmr_en, tmr_evt, tmr_hit, hs;
  logic [CNT_W-1:0]  tmr_limit;
  logic [ADDR_W-1:0] cfg_addr;
  logic [DATA_W-1:0] cfg_data;

  assign fault = brownout_i | ~pwr_good_i;
  assign hs    = wr_valid_o & wr_ready_i;

  codec_lrck_edge u_lrck (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .lrck_i (lrck_i),
    .rise_o (lrck_rise)
  );

  // one counter serves the settle, init and guard waits
  assign tmr_en  = (state_q == ST_SETTLE) || (state_q == ST_INIT_WAIT) ||
                   (state_q == ST_UNMUTE_WAIT);
  assign tmr_evt = (state_q == ST_SETTLE) ? ms_tick_i : lrck_rise;

  always_comb begin
    case (state_q)
      ST_SETTLE:    tmr_limit = CNT_W'(SETTLE_MS);
      ST_INIT_WAIT: tmr_limit = CNT_W'(INIT_LRCK);
      default:      tmr_limit = CNT_W'(UNMUTE_LRCK);
    endcase
  end

  codec_evt_timer #(.CNT_W(CNT_W)) u_tmr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (tmr_en),
    .evt_i   (tmr_evt),
    .limit_i (tmr_limit),
    .hit_o   (tmr_hit)
  );

  codec_cfg_rom #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .CFG_N    (CFG_N),
    .CFG_BASE (CFG_BASE),
    .IDX_W    (IDX_W)
  ) u_rom (
    .idx_i  (idx_q),
    .addr_o (cfg_addr),
    .data_o (cfg_data)
  );

  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    if (fault) begin
      state_d = ST_RESET;
      idx_d   = '0;
    end else begin
      case (state_q)
        ST_RESET:       state_d = ST_SETTLE;
        ST_SETTLE:      if (tmr_hit) state_d = ST_PDN_SET;
        ST_PDN_SET:     if (hs) state_d = ST_CFG;
        ST_CFG: begin
          if (hs) begin
            if (idx_q == IDX_W'(CFG_N - 1)) begin
              state_d = ST_MUTE;
              idx_d   = '0;
            end else begin
              idx_d = idx_q + IDX_W'(1);
            end
          end
        end
        ST_MUTE:        if (hs) state_d = ST_PDN_CLR;
        ST_PDN_CLR:     if (hs) state_d = ST_INIT_WAIT;
        ST_INIT_WAIT:   if (tmr_hit) state_d = ST_UNMUTE_WAIT;
        ST_UNMUTE_WAIT: if (tmr_hit) state_d = ST_UNMUTE;
        ST_UNMUTE:      if (hs) state_d = ST_READY;
        default:        state_d = state_q;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_RESET;
      idx_q   <= '0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
    end
  end

  always_comb begin
    wr_valid_o = 1'b1;
    wr_addr_o  = '0;
    wr_data_o  = '0;
    case (state_q)
      ST_PDN_SET: begin
        wr_addr_o = ADDR_W'(PDN_ADDR);
        wr_data_o = DATA_W'(1);
      end
      ST_CFG: begin
        wr_addr_o = cfg_addr;
        wr_data_o = cfg_data;
      end
      ST_MUTE: begin
        wr_addr_o = ADDR_W'(MUTE_ADDR);
        wr_data_o = DATA_W'(MUTE_VAL);
      end
      ST_PDN_CLR: begin
        wr_addr_o = ADDR_W'(PDN_ADDR);
        wr_data_o = '0;
      end
      ST_UNMUTE: begin
        wr_addr_o = ADDR_W'(MUTE_ADDR);
        wr_data_o = DATA_W'(UNMUTE_VAL);
      end
      default: wr_valid_o = 1'b0;
    endcase
  end

  assign codec_rst_n_o = (state_q != ST_RESET);
  assign ready_o       = (state_q == ST_READY);
  assign busy_o        = (state_q != ST_RESET) && (state_q != ST_READY);

  p_supply_hold_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pwr_good_i |=> !codec_rst_n_o);

  p_fault_clears_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault |=> (!codec_rst_n_o && !ready_o && !wr_valid_o));

  p_req_stable_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_valid_o && !wr_ready_i && !fault) |=>
      (wr_valid_o && $stable(wr_addr_o) && $stable(wr_data_o)));

  p_ready_cause_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ready_o) |-> $past(hs && wr_addr_o == ADDR_W'(MUTE_ADDR) &&
                             wr_data_o == DATA_W'(UNMUTE_VAL)));

  p_no_req_in_reset_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !codec_rst_n_o |-> !wr_valid_o);

endmodule

// File: tb/codec_pwrup_seq_tb.sv
module codec_pwrup_seq_tb_top;
  localparam int CLK_PERIOD  = 10;
  localparam int CFG_N       = 5;
  localparam int SETTLE_MS   = 7;
  localparam int INIT_LRCK   = 12;
  localparam int UNMUTE_LRCK = 4;
  localparam int N_WR        = CFG_N + 4;

  logic clk = 1'b0;
  logic rst_n, pwr_good, brownout, lrck, ms_tick, wr_ready;
  logic codec_rst_n, wr_valid, ready, busy;
  logic [7:0] wr_addr, wr_data;

  always #(CLK_PERIOD / 2) clk = ~clk;

  codec_pwrup_seq #(
    .ADDR_W(8), .DATA_W(8), .CFG_N(CFG_N), .CFG_BASE(6), .PDN_ADDR(2),
    .MUTE_ADDR(5), .MUTE_VAL(255), .UNMUTE_VAL(0), .SETTLE_MS(SETTLE_MS),
    .INIT_LRCK(INIT_LRCK), .UNMUTE_LRCK(UNMUTE_LRCK)
  ) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .pwr_good_i(pwr_good), .brownout_i(brownout),
    .lrck_i(lrck), .ms_tick_i(ms_tick), .codec_rst_n_o(codec_rst_n),
    .wr_addr_o(wr_addr), .wr_data_o(wr_data), .wr_valid_o(wr_valid),
    .wr_ready_i(wr_ready), .ready_o(ready), .busy_o(busy)
  );

  int n_checks = 0, n_fail = 0;
  bit done = 0;
  logic [7:0] log_a [0:31];
  logic [7:0] log_d [0:31];
  int log_n, settle_ticks, lrck_rises, unmute_rises;
  bit lrck_run, rsp_en, hold_v;
  logic [7:0] hold_a, hold_d;

  task automatic chk(bit ok, string req, string what, int act, int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_write(int k);
    int v;
    if (k == 0) return {8'h02, 8'h01};
    if (k <= CFG_N) begin
      v = ((k - 1) * 29) ^ 165;
      return {8'(6 + k - 1), v[7:0]};
    end
    if (k == CFG_N + 1) return {8'h05, 8'hFF};
    if (k == CFG_N + 2) return {8'h02, 8'h00};
    return {8'h05, 8'h00};
  endfunction

  function automatic string req_of(int k);
    if (k == 0) return "R3";
    if (k <= CFG_N) return "R4";
    if (k <= CFG_N + 2) return "R5";
    return "R6";
  endfunction

  // millisecond tick source; counts ticks the design consumes while settling
  initial begin
    ms_tick = 1'b0;
    forever begin
      @(negedge clk);
      ms_tick = ($urandom_range(0, 2) == 0);
      if (ms_tick && codec_rst_n && !wr_valid && log_n == 0) settle_ticks++;
    end
  end

  // frame clock: 8-cycle period, runs only during the post-power-down wait
  initial begin
    int ph;
    ph = 7;
    lrck = 1'b0;
    forever begin
      @(negedge clk);
      if (lrck_run) begin
        ph = (ph + 1) % 8;
        lrck = (ph < 4);
        if (ph == 0) lrck_rises++;
      end else begin
        ph = 7;
        lrck = 1'b0;
      end
    end
  end

  // write responder with random acceptance delay
  initial begin
    int dly;
    dly = 0;
    wr_ready = 1'b0;
    forever begin
      @(negedge clk);
      if (wr_ready) begin
        wr_ready = 1'b0;
        hold_v = 0;
        // R7: ready follows the accepted unmute write by one cycle
        if (log_n == N_WR) chk(ready === 1'b1, "R7", "ready after unmute", ready, 1);
        if (log_n == CFG_N + 3) lrck_run = 1;
      end else if (wr_valid && rsp_en) begin
        if (hold_v) begin
          chk(wr_addr === hold_a && wr_data === hold_d, "R8", "request held",
              {wr_addr, wr_data}, {hold_a, hold_d});
        end
        if (log_n == CFG_N + 3 && lrck_run) begin
          unmute_rises = lrck_rises;
          lrck_run = 0;
        end
        if (dly == 0) begin
          if (log_n == CFG_N + 3) chk(ready === 1'b0, "R7", "ready before unmute", ready, 0);
          wr_ready = 1'b1;
          if (log_n < 32) begin
            log_a[log_n] = wr_addr;
            log_d[log_n] = wr_data;
          end
          log_n++;
          dly = $urandom_range(0, 3);
        end else begin
          dly--;
          hold_v = 1;
          hold_a = wr_addr;
          hold_d = wr_data;
        end
      end
    end
  end

  task automatic start_seq();
    log_n = 0;
    settle_ticks = 0;
    lrck_rises = 0;
    unmute_rises = -1;
    lrck_run = 0;
    hold_v = 0;
    rsp_en = 1;
    brownout = 1'b0;
    pwr_good = 1'b1;
  endtask

  task automatic finish_seq(string tag);
    int cyc;
    cyc = 0;
    while (!ready && cyc < 5000) begin
      @(negedge clk);
      cyc++;
    end
    chk(cyc < 5000, "R7", {tag, " watchdog ready"}, cyc, 0);
    chk(settle_ticks == SETTLE_MS, "R2", {tag, " settle ticks"}, settle_ticks, SETTLE_MS);
    chk(log_n == N_WR, "R6", {tag, " write count"}, log_n, N_WR);
    for (int k = 0; k < N_WR && k < log_n; k++)
      chk({log_a[k], log_d[k]} == exp_write(k), req_of(k), {tag, " write"},
          {log_a[k], log_d[k]}, exp_write(k));
    chk(unmute_rises == INIT_LRCK + UNMUTE_LRCK, "R6", {tag, " lrck edges"},
        unmute_rises, INIT_LRCK + UNMUTE_LRCK);
    @(negedge clk);
    chk(ready === 1'b1 && busy === 1'b0, "R7", {tag, " ready/busy"}, {ready, busy}, 2'b10);
  endtask

  task automatic fault_check(string tag);
    @(negedge clk);
    chk(codec_rst_n === 1'b0 && ready === 1'b0 && wr_valid === 1'b0, "R9",
        {tag, " fault response"}, {codec_rst_n, ready, wr_valid}, 0);
  endtask

  initial begin
    rst_n = 1'b0; pwr_good = 1'b0; brownout = 1'b0; rsp_en = 0;
    log_n = 0; lrck_run = 0;
    void'($urandom(32'h5eed_c0de));
    repeat (5) @(negedge clk);
    chk(codec_rst_n === 1'b0 && wr_valid === 1'b0 && ready === 1'b0 && busy === 1'b0,
        "R1", "reset state", {codec_rst_n, wr_valid, ready, busy}, 0);
    rst_n = 1'b1;
    repeat ($urandom_range(10, 20)) @(negedge clk);
    chk(codec_rst_n === 1'b0 && wr_valid === 1'b0, "R1", "held while supply bad",
        {codec_rst_n, wr_valid}, 0);

    start_seq();
    @(negedge clk);
    chk(codec_rst_n === 1'b1 && busy === 1'b1 && wr_valid === 1'b0, "R2", "reset released",
        {codec_rst_n, busy, wr_valid}, 3'b110);
    finish_seq("seq1");

    // brownout while ready
    brownout = 1'b1;
    fault_check("in ready");
    repeat (3) @(negedge clk);
    start_seq();
    finish_seq("seq2");

    // brownout during the frame-clock wait
    brownout = 1'b1;
    @(negedge clk);
    start_seq();
    while (!lrck_run) @(negedge clk);
    repeat ($urandom_range(20, 60)) @(negedge clk);
    rsp_en = 0;
    brownout = 1'b1;
    fault_check("in init wait");
    repeat (2) @(negedge clk);
    start_seq();
    finish_seq("seq3");

    // supply drop during configuration writes
    pwr_good = 1'b0;
    @(negedge clk);
    start_seq();
    while (log_n < 3) @(negedge clk);
    rsp_en = 0;
    repeat (2) @(negedge clk);
    pwr_good = 1'b0;
    fault_check("supply drop");
    chk(codec_rst_n === 1'b0, "R1", "supply low holds reset", codec_rst_n, 0);
    repeat (4) @(negedge clk);
    start_seq();
    finish_seq("seq4");

    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      done = 1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired actual=0x0 expected=0x1");
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end

endmodule